// File: doc/BRIEF.md
# Regulator and Low-Supply Interrupt Control Register

This block is one 8-bit control register. It decides whether an on-chip supply regulator is switched on, and whether a low-supply interrupt is sent to the host. Software writes the register through a simple strobe-and-data port. The register contents drive three things: the regulator's target-voltage select, the threshold select of the supply comparator, and the regulator on/off decision.

The regulator decision combines three inputs: a regulator-enable bit, a mode-force bit and the chip's sleep status. When force is set, the enable bit alone decides, and sleep has no effect. When force is clear, the regulator runs only while the chip is awake and the enable bit is set.

The interrupt output is a registered level. It is raised only when all of these are true: the interrupt enable bit is set, the comparator reports low supply, the chip is awake and the regulator is on. A read returns the stored bits with a live status bit inserted at position 4. That status bit shows whether the regulator is on.

Top module: `pwr_ctl_reg`

## Requirements
- R1: After reset, rdData reads 8'hB0. Bit 7 (enable) is 1, bit 6 (interrupt enable) is 0, bit 5 (force) is 1, status bit 4 is 1, and all select bits are 0. regEn is 1 and lvIrq is 0.
- R2: A write is captured at the rising edge where wrEn is high. From the next cycle, rdData bits 7:5 and 3:0 equal the written bits. Bit 4 of the written byte has no effect on the read value.
- R3: rdData bit 4 always reads the current value of regEn.
- R4: With enable=1 and force=1, regEn is 1 whether sleepIn is high or low.
- R5: With enable=0 and force=1, regEn is 0 whether sleepIn is high or low.
- R6: With enable=1 and force=0, regEn equals the inverse of sleepIn.
- R7: With enable=0 and force=0, regEn is 0.
- R8: lvIrq rises one cycle after all four of these hold: interrupt enable, lowSupply, sleepIn low and regEn high. It falls one cycle after any of them stops holding.
- R9: lvIrq stays low while the interrupt enable bit is 0, while sleepIn is high, or while regEn is 0.
- R10: lvThSel carries register bits 3:2 and outvSel carries bits 1:0.
  - Threshold codes: 11 = 1.8 V, 10 = 2.0 V, 01 = 2.2 V, 00 = follow the regulator setting.
  - Output codes: 11 = 2.4 V, 10 = 2.5 V, 01 = 2.6 V, 00 = 2.7 V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the register |
| wrData | input | 8 | Write data |
| sleepIn | input | 1 | High while the chip is in sleep |
| lowSupply | input | 1 | Comparator output: supply is below the selected threshold |
| rdData | output | 8 | Register contents, with the regulator status at bit 4 |
| regEn | output | 1 | Regulator enable |
| outvSel | output | 2 | Regulator output-voltage select |
| lvThSel | output | 2 | Low-supply threshold select |
| lvIrq | output | 1 | Low-supply interrupt request, level |

## Verification
The properties assume that sleepIn and lowSupply are synchronous to clk and change only between edges. They also assume that a write is a single-cycle strobe with its data held stable across the capturing edge. The stimulus meets these assumptions: every input is driven at the falling edge and held for at least one full cycle. The bench changes sleep and comparator levels only after the write that sets up a case has completed. This keeps each regEn and lvIrq observation tied to exactly one configuration.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int CFG_W     = 8;
  localparam int SEL_W     = 2;
  localparam int EN_BIT    = 7;
  localparam int IRQEN_BIT = 6;
  localparam int FORCE_BIT = 5;
  localparam int STAT_BIT  = 4;
  localparam int TH_LSB    = 2;
  localparam int OUTV_LSB  = 0;
  localparam logic [CFG_W-1:0] CFG_RST  = 8'b1010_0000;
  localparam logic [CFG_W-1:0] STAT_MSK = CFG_W'(1) << STAT_BIT;

  typedef struct packed {
    logic loadCfg;  // capture write data this edge
    logic regOn;    // regulator decision for this cycle
    logic irqArm;   // interrupt condition to be registered
  } pwr_strb_t;
endpackage

// File: rtl/pwr_ctl_ctrl.sv
module pwr_ctl_ctrl
  import pwr_ctl_pkg::*;
(
  input  logic      wrEn,
  input  logic      sleepIn,
  input  logic      lowSupply,
  input  logic      cfgEn,
  input  logic      cfgIrqEn,
  input  logic      cfgForce,
  output pwr_strb_t strb
);
  logic regOn;

  // Force: the enable bit alone decides. Otherwise the regulator is off in sleep.
  always_comb begin
    if (cfgForce) regOn = cfgEn;
    else          regOn = cfgEn & ~sleepIn;
  end

  always_comb begin
    strb.loadCfg = wrEn;
    strb.regOn   = regOn;
    strb.irqArm  = cfgIrqEn & lowSupply & ~sleepIn & regOn;
  end
endmodule

// File: rtl/pwr_ctl_dp.sv
module pwr_ctl_dp
  import pwr_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pwr_strb_t        strb,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] cfgQ,
  output logic [CFG_W-1:0] rdData,
  output logic             lvIrq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgQ <= CFG_RST;
    else if (strb.loadCfg) cfgQ <= wrData & ~STAT_MSK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvIrq <= 1'b0;
    else       lvIrq <= strb.irqArm;
  end

  // Read value: stored bits, with the live regulator status at bit 4.
  always_comb begin
    rdData           = cfgQ;
    rdData[STAT_BIT] = strb.regOn;
  end
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  input  logic             sleepIn,
  input  logic             lowSupply,
  output logic [CFG_W-1:0] rdData,
  output logic             regEn,
  output logic [SEL_W-1:0] outvSel,
  output logic [SEL_W-1:0] lvThSel,
  output logic             lvIrq
);
  pwr_strb_t        strb;
  logic [CFG_W-1:0] cfgQ;

  pwr_ctl_ctrl i_ctrl (
    .wrEn      (wrEn),
    .sleepIn   (sleepIn),
    .lowSupply (lowSupply),
    .cfgEn     (cfgQ[EN_BIT]),
    .cfgIrqEn  (cfgQ[IRQEN_BIT]),
    .cfgForce  (cfgQ[FORCE_BIT]),
    .strb      (strb)
  );

  pwr_ctl_dp i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .cfgQ   (cfgQ),
    .rdData (rdData),
    .lvIrq  (lvIrq)
  );

  assign regEn   = strb.regOn;
  assign outvSel = cfgQ[OUTV_LSB +: SEL_W];
  assign lvThSel = cfgQ[TH_LSB +: SEL_W];
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk
  import pwr_ctl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CFG_W-1:0] wrData,
  input logic             sleepIn,
  input logic             lowSupply,
  input logic [CFG_W-1:0] rdData,
  input logic             regEn,
  input logic             lvIrq
);
  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ({rdData[7:5], rdData[3:0]} == $past({wrData[7:5], wrData[3:0]}))); // R2
  AST_FORCED_ON: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[EN_BIT] && wrData[FORCE_BIT]) |=> regEn); // R4
  AST_FORCED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[EN_BIT] && wrData[FORCE_BIT]) |=> !regEn); // R5
  AST_SLEEP_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[EN_BIT] && !wrData[FORCE_BIT]) |=> (regEn == !sleepIn)); // R6
  AST_BOTH_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[EN_BIT] && !wrData[FORCE_BIT]) |=> !regEn); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[IRQEN_BIT] && lowSupply && !sleepIn && regEn) |=> lvIrq); // R8
  AST_IRQ_NO_EN: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[IRQEN_BIT] |=> !lvIrq); // R9
  AST_IRQ_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |=> !lvIrq); // R9
  AST_IRQ_REG_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !regEn |=> !lvIrq); // R9
endmodule

bind pwr_ctl_reg pwr_ctl_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .sleepIn   (sleepIn),
  .lowSupply (lowSupply),
  .rdData    (rdData),
  .regEn     (regEn),
  .lvIrq     (lvIrq)
);

// File: tb/test_pwr_ctl_reg.sv
module test_pwr_ctl_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       sleepIn = 1'b0;
  logic       lowSupply = 1'b0;
  logic [7:0] rdData;
  logic       regEn;
  logic [1:0] outvSel;
  logic [1:0] lvThSel;
  logic       lvIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #2ns clk = ~clk;

  pwr_ctl_reg i_pwr_ctl_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .sleepIn(sleepIn), .lowSupply(lowSupply), .rdData(rdData),
    .regEn(regEn), .outvSel(outvSel), .lvThSel(lvThSel), .lvIrq(lvIrq)
  );

  // Vector fields: {cfg[7:0], sleep, low, expRegEn, expIrq, reqId[3:0]}
  localparam int NV = 10;
  localparam logic [15:0] VEC [NV] = '{
    {8'hE0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd8},   // all irq conditions met
    {8'hE0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd4},   // forced on in sleep, irq muted
    {8'h60, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},   // forced off, irq muted
    {8'hC0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},   // follow sleep, awake
    {8'hC0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6},   // follow sleep, asleep
    {8'h40, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},   // enable and force clear
    {8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},
    {8'hA0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9},   // irq enable clear
    {8'hE0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8},   // supply fine
    {8'hBD, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2}    // bit 4 written high, selects set
  };

  function automatic string tagOf(input logic [3:0] id);
    case (id)
      4'd2: return "R2";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 4ns);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset rdData", rdData, 8'hB0);
    check("R1", "reset regEn", {7'd0, regEn}, 8'h01);
    check("R1", "reset lvIrq", {7'd0, lvIrq}, 8'h00);
    check("R1", "reset selects", {4'd0, lvThSel, outvSel}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] cfg;
      logic [7:0] expRd;
      cfg = VEC[i][15:8];
      writeCfg(cfg);
      sleepIn = VEC[i][7];
      lowSupply = VEC[i][6];
      #1ns;
      check(tagOf(VEC[i][3:0]), "regEn", {7'd0, regEn}, {7'd0, VEC[i][5]});
      expRd = (cfg & 8'hEF) | {3'd0, VEC[i][5], 4'd0};
      check("R2", "rdData", rdData, expRd);
      check("R3", "status bit", {7'd0, rdData[4]}, {7'd0, regEn});
      check("R10", "selects", {4'd0, lvThSel, outvSel}, {4'd0, cfg[3:0]});
      @(negedge clk);
      check(tagOf(VEC[i][3:0]), "lvIrq", {7'd0, lvIrq}, {7'd0, VEC[i][4]});
    end

    // R8: one-cycle rise and fall latency
    writeCfg(8'hE0);
    sleepIn = 1'b0; lowSupply = 1'b0;
    @(negedge clk);
    lowSupply = 1'b1;
    #1ns;
    check("R8", "irq before edge", {7'd0, lvIrq}, 8'h00);
    @(negedge clk);
    check("R8", "irq raised", {7'd0, lvIrq}, 8'h01);
    lowSupply = 1'b0;
    #1ns;
    check("R8", "irq held until edge", {7'd0, lvIrq}, 8'h01);
    @(negedge clk);
    check("R8", "irq dropped", {7'd0, lvIrq}, 8'h00);

    // R9: entering sleep with force clear turns off regulator and irq
    writeCfg(8'hC0);
    lowSupply = 1'b1;
    @(negedge clk);
    check("R9", "irq awake", {7'd0, lvIrq}, 8'h01);
    sleepIn = 1'b1;
    @(negedge clk);
    check("R9", "irq in sleep", {7'd0, lvIrq}, 8'h00);
    check("R6", "regEn in sleep", {7'd0, regEn}, 8'h00);

    // R10: other select codes
    writeCfg(8'h0E);
    check("R10", "threshold", {6'd0, lvThSel}, 8'h03);
    check("R10", "output", {6'd0, outvSel}, 8'h02);
    check("R7", "both clear", {7'd0, regEn}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule